// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides, one request at a time, whether a cache-block operation may go ahead. A request carries the operation (zero, clean, flush or invalidate), the current privilege level, the virtualization flag, an effective address, and the per-level enable fields from the machine, hypervisor and supervisor environment-configuration registers. The block first applies a fixed sequence of enable gates. The first gate that fails sets the exception code. If every gate passes, the block asks an external translation and protection unit whether the aligned block may be accessed.

The zero operation needs store permission. Clean, flush and invalidate are allowed when a load to the block is permitted. When the load is refused, they fall back to a store probe. Every request ends in a one-cycle result pulse that carries an allow flag, an exception code, and the address aligned down to the block size.

Top module: `cbo_perm_check`

## Requirements
- R1: If privilege is not machine (machine = 3, supervisor = 1, user = 0) and the machine enable bit for the operation is 0, the result is refused with exception code 2. This check takes precedence over every other check.
- R2: If R1 passes and virtualization is on, the result is refused with exception code 22 in either of two cases: privilege is not machine and the hypervisor enable bit is 0, or privilege is user and the supervisor enable bit is 0.
- R3: If R1 and R2 pass, privilege is user and the supervisor enable bit is 0, the result is refused with exception code 2.
- R4: Operation codes are zero = 0, clean = 1, flush = 2 and invalidate = 3. Each 3-bit enable field holds the zero enable in bit 0, the shared clean/flush enable in bit 1 and the invalidate enable in bit 2.
- R5: The probe address and the result address both equal the request address with its low log2(BLK_BYTES) bits cleared.
- R6: A zero operation that passes the gates issues exactly one store probe and no load probe. An accepted store is allowed with code 0. A refused store gives code 15, or code 23 when virtualization is on.
- R7: A clean, flush or invalidate that passes the gates issues a load probe first. If the load is accepted, the result is allowed with code 0 and no store probe is issued.
- R8: If that load is refused, exactly one store probe follows. An accepted store is allowed. A refused store gives code 15, or 23 when virtualization is on.
- R9: A request refused by an enable gate issues no probe, and its result pulse is present in the cycle right after acceptance.
- R10: prb_valid stays high, with prb_addr and prb_store stable, until prb_ready. res_valid lasts exactly one cycle. req_ready is high only when no request is in flight.
- R11: After reset, req_ready is 1 and res_valid and prb_valid are 0.
- R12: At machine privilege every enable gate is skipped, whatever the enable fields hold, and the request goes directly to probing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Checker idle, request accepted |
| req_op | input | 2 | Operation: 0 zero, 1 clean, 2 flush, 3 invalidate |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Virtualization mode on |
| req_addr | input | AW | Effective address |
| m_en | input | 3 | Machine-level enables {inval, clean/flush, zero} |
| h_en | input | 3 | Hypervisor-level enables, same layout |
| s_en | input | 3 | Supervisor-level enables, same layout |
| prb_valid | output | 1 | Permission probe request |
| prb_ready | input | 1 | Probe request taken |
| prb_store | output | 1 | Probe kind: 1 store, 0 load |
| prb_addr | output | AW | Aligned block address for the probe |
| rsp_valid | input | 1 | Probe response present |
| rsp_ok | input | 1 | Probe permitted |
| res_valid | output | 1 | Result pulse |
| res_allow | output | 1 | Operation may execute |
| res_exc | output | 5 | Exception code, 0 when allowed |
| res_addr | output | AW | Aligned block address |

## Verification
The bound checker watches several properties on every cycle. It checks that the machine-level gate refuses with code 2 in the cycle after acceptance, and that machine privilege always leads directly to a probe of the right kind. It also covers probe-handshake stability, address alignment, the single-cycle result pulse and the zero code on allowed results. Only the bench scenarios can show the full ordering of the three gates against each other. The same holds for choosing between codes 15 and 23, for the load-then-store fallback with its exact probe counts, and for behaviour under probe-ready delays. Those depend on responses the bench's probe model supplies.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
    localparam int EN_W  = 3;
    localparam int EXC_W = 5;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_INVAL = 2'd3
    } cbo_op_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [EXC_W-1:0] EXC_NONE     = 5'd0;
    localparam logic [EXC_W-1:0] EXC_ILLEGAL  = 5'd2;
    localparam logic [EXC_W-1:0] EXC_ST_PAGE  = 5'd15;
    localparam logic [EXC_W-1:0] EXC_VIRT_INS = 5'd22;
    localparam logic [EXC_W-1:0] EXC_ST_GUEST = 5'd23;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } chk_state_e;
endpackage

// File: rtl/cbo_enable_gate.sv
module cbo_enable_gate
    import cbo_pkg::*;
(
    input  cbo_op_e               op,
    input  logic [1:0]            priv,
    input  logic                  virt,
    input  logic [EN_W-1:0]       m_en,
    input  logic [EN_W-1:0]       h_en,
    input  logic [EN_W-1:0]       s_en,
    output logic                  fail,
    output logic [EXC_W-1:0]      exc
);
    logic [EN_W-1:0] sel;
    logic m_bit, h_bit, s_bit;
    logic below_m, is_user;
    logic m_fail, v_fail, s_fail;

    // one-hot selection of the enable bit that governs this operation
    always_comb begin
        sel = '0;
        unique case (op)
            OP_ZERO:  sel[0] = 1'b1;
            OP_INVAL: sel[2] = 1'b1;
            default:  sel[1] = 1'b1;
        endcase
    end

    assign m_bit   = |(m_en & sel);
    assign h_bit   = |(h_en & sel);
    assign s_bit   = |(s_en & sel);
    assign below_m = (priv != PRIV_M);
    assign is_user = (priv == PRIV_U);

    assign m_fail = below_m && !m_bit;
    assign v_fail = virt && ((below_m && !h_bit) || (is_user && !s_bit));
    assign s_fail = is_user && !s_bit;

    // priority: machine gate, then virtualized gate, then supervisor gate
    always_comb begin
        fail = 1'b1;
        if (m_fail)      exc = EXC_ILLEGAL;
        else if (v_fail) exc = EXC_VIRT_INS;
        else if (s_fail) exc = EXC_ILLEGAL;
        else begin
            fail = 1'b0;
            exc  = EXC_NONE;
        end
    end
endmodule

// File: rtl/cbo_block_align.sv
module cbo_block_align #(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] OFF_MASK = AW'(BLK_BYTES - 1);

    initial begin
        if ((BLK_BYTES & (BLK_BYTES - 1)) != 0)
            $error("block size must be a power of two");
    end

    assign addr_o = addr_i & ~OFF_MASK;
endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
    import cbo_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [1:0]           req_priv,
    input  logic                 req_virt,
    input  logic [AW-1:0]        req_addr,
    input  logic [EN_W-1:0]      m_en,
    input  logic [EN_W-1:0]      h_en,
    input  logic [EN_W-1:0]      s_en,
    output logic                 prb_valid,
    input  logic                 prb_ready,
    output logic                 prb_store,
    output logic [AW-1:0]        prb_addr,
    input  logic                 rsp_valid,
    input  logic                 rsp_ok,
    output logic                 res_valid,
    output logic                 res_allow,
    output logic [EXC_W-1:0]     res_exc,
    output logic [AW-1:0]        res_addr
);
    typedef struct packed {
        chk_state_e         state;
        logic               virt;
        logic               store_phase;
        logic [AW-1:0]      addr;
        logic               allow;
        logic [EXC_W-1:0]   exc;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic             gate_fail;
    logic [EXC_W-1:0] gate_exc;
    logic [AW-1:0]    aligned;

    cbo_enable_gate u_gate (
        .op   (cbo_op_e'(req_op)),
        .priv (req_priv),
        .virt (req_virt),
        .m_en (m_en),
        .h_en (h_en),
        .s_en (s_en),
        .fail (gate_fail),
        .exc  (gate_exc)
    );

    cbo_block_align #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_align (
        .addr_i (req_addr),
        .addr_o (aligned)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.addr  = aligned;
                    ctx_d.virt  = req_virt;
                    ctx_d.allow = 1'b0;
                    if (gate_fail) begin
                        ctx_d.exc   = gate_exc;
                        ctx_d.state = ST_DONE;
                    end else begin
                        ctx_d.exc         = EXC_NONE;
                        ctx_d.store_phase = (cbo_op_e'(req_op) == OP_ZERO);
                        ctx_d.state       = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (prb_ready) ctx_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_ok) begin
                        ctx_d.allow = 1'b1;
                        ctx_d.exc   = EXC_NONE;
                        ctx_d.state = ST_DONE;
                    end else if (!ctx_q.store_phase) begin
                        ctx_d.store_phase = 1'b1;
                        ctx_d.state       = ST_ISSUE;
                    end else begin
                        ctx_d.allow = 1'b0;
                        ctx_d.exc   = ctx_q.virt ? EXC_ST_GUEST : EXC_ST_PAGE;
                        ctx_d.state = ST_DONE;
                    end
                end
            end
            default: ctx_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{state: ST_IDLE, virt: 1'b0, store_phase: 1'b0,
                       addr: '0, allow: 1'b0, exc: EXC_NONE};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready = (ctx_q.state == ST_IDLE);
    assign prb_valid = (ctx_q.state == ST_ISSUE);
    assign prb_store = ctx_q.store_phase;
    assign prb_addr  = ctx_q.addr;
    assign res_valid = (ctx_q.state == ST_DONE);
    assign res_allow = ctx_q.allow;
    assign res_exc   = ctx_q.exc;
    assign res_addr  = ctx_q.addr;
endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva #(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic [1:0]    req_priv,
    input logic [2:0]    m_en,
    input logic          prb_valid,
    input logic          prb_ready,
    input logic          prb_store,
    input logic [AW-1:0] prb_addr,
    input logic          res_valid,
    input logic          res_allow,
    input logic [4:0]    res_exc,
    input logic [AW-1:0] res_addr
);
    localparam logic [AW-1:0] LOW_MASK = AW'(BLK_BYTES - 1);

    logic       accept;
    logic [1:0] bit_idx;

    assign accept  = req_valid && req_ready;
    assign bit_idx = (req_op == 2'd0) ? 2'd0 : (req_op == 2'd3) ? 2'd2 : 2'd1;

    p_mach_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_priv != 2'd3 && !m_en[bit_idx])
        |=> (res_valid && !res_allow && res_exc == 5'd2));

    p_mach_bypass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_priv == 2'd3) |=> (prb_valid && !res_valid));

    p_zero_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_priv == 2'd3 && req_op == 2'd0) |=> prb_store);

    p_load_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_priv == 2'd3 && req_op != 2'd0) |=> !prb_store);

    p_probe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid && !prb_ready)
        |=> (prb_valid && $stable(prb_addr) && $stable(prb_store)));

    p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || prb_valid) |-> !req_ready);

    p_probe_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid |-> ((prb_addr & LOW_MASK) == '0));

    p_res_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_addr & LOW_MASK) == '0));

    p_allow_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_allow) |-> (res_exc == 5'd0));
endmodule

bind cbo_perm_check cbo_perm_check_sva #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_sva (.*);

// File: tb/cbo_perm_check_tb.sv
module cbo_perm_check_tb;
    localparam int AW = 32;
    localparam int BLK = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_priv = '0;
    logic          req_virt = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    m_en = '0, h_en = '0, s_en = '0;
    logic          prb_valid, prb_store;
    logic          prb_ready = 1'b0;
    logic [AW-1:0] prb_addr;
    logic          rsp_valid = 1'b0, rsp_ok = 1'b0;
    logic          res_valid, res_allow;
    logic [4:0]    res_exc;
    logic [AW-1:0] res_addr;

    always #4 clk = ~clk;

    cbo_perm_check #(.AW(AW), .BLK_BYTES(BLK)) u_dut (.*);

    typedef struct {
        bit          allow;
        logic [4:0]  exc;
        logic [31:0] addr;
        int          loads;
        int          stores;
        bit          gated;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_fail = 0;
    int   n_ld = 0, n_st = 0;
    bit   ld_ok = 1'b0, st_ok = 1'b0;
    int   rdy_dly = 0;
    logic [31:0] cur_addr = '0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [1:0] op, input logic [1:0] pv,
                                   input bit vt, input logic [2:0] me,
                                   input logic [2:0] he, input logic [2:0] se,
                                   input logic [31:0] a, input bit lok,
                                   input bit sok, input string tag);
        exp_t e;
        int   b;
        b = (op == 2'd0) ? 0 : (op == 2'd3) ? 2 : 1;
        e.tag = tag; e.addr = a & ~32'(BLK - 1);
        e.loads = 0; e.stores = 0; e.allow = 0; e.exc = 0; e.gated = 1;
        if (pv != 2'd3 && !me[b]) e.exc = 5'd2;
        else if (vt && ((pv != 2'd3 && !he[b]) || (pv == 2'd0 && !se[b]))) e.exc = 5'd22;
        else if (pv == 2'd0 && !se[b]) e.exc = 5'd2;
        else begin
            e.gated = 0;
            if (op != 2'd0) e.loads = 1;
            if (op != 2'd0 && lok) e.allow = 1;
            else begin
                e.stores = 1;
                e.allow  = sok;
                e.exc    = sok ? 5'd0 : (vt ? 5'd23 : 5'd15);
            end
        end
        return e;
    endfunction

    task automatic send(input logic [1:0] op, input logic [1:0] pv, input bit vt,
                        input logic [2:0] me, input logic [2:0] he,
                        input logic [2:0] se, input logic [31:0] a,
                        input bit lok, input bit sok, input int dly,
                        input string tag);
        exp_t e;
        while (!req_ready) @(negedge clk);
        e = model(op, pv, vt, me, he, se, a, lok, sok, tag);
        exp_q.push_back(e);
        ld_ok = lok; st_ok = sok; rdy_dly = dly; cur_addr = e.addr;
        req_op = op; req_priv = pv; req_virt = vt;
        m_en = me; h_en = he; s_en = se; req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (e.gated) chk(res_valid == 1'b1, {"R9 result next cycle ", tag}, res_valid, 1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // probe responder: counts probes and checks their address
    initial begin
        forever begin
            @(negedge clk);
            if (prb_valid) begin
                repeat (rdy_dly) @(negedge clk);
                chk(prb_addr == cur_addr, "R5 probe address", prb_addr, cur_addr);
                prb_ready = 1'b1;
                if (prb_store) n_st++; else n_ld++;
                rsp_ok = prb_store ? st_ok : ld_ok;
                @(negedge clk);
                prb_ready = 1'b0;
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // monitor: compares each result pulse against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(res_allow == e.allow, {e.tag, " allow"}, res_allow, e.allow);
                    chk(res_exc == e.exc, {e.tag, " code"}, res_exc, e.exc);
                    chk(res_addr == e.addr, {"R5 ", e.tag, " addr"}, res_addr, e.addr);
                    chk(n_ld == e.loads, {e.tag, " load probes"}, n_ld, e.loads);
                    chk(n_st == e.stores, {e.tag, " store probes"}, n_st, e.stores);
                end
                n_ld = 0; n_st = 0;
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
        chk(res_valid == 1'b0, "R11 no result after reset", res_valid, 0);
        chk(prb_valid == 1'b0, "R11 no probe after reset", prb_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // machine privilege ignores empty enables
        send(2'd3, 2'd3, 0, 3'b000, 3'b000, 3'b000, 32'h0000_1234, 1, 0, 0, "R12 R7 mach inval");
        send(2'd1, 2'd3, 1, 3'b000, 3'b000, 3'b000, 32'h0000_2040, 0, 1, 2, "R12 R8 mach clean");
        // machine gate
        send(2'd0, 2'd1, 0, 3'b110, 3'b111, 3'b111, 32'h0000_0080, 1, 1, 0, "R1 sup zero");
        send(2'd2, 2'd0, 1, 3'b101, 3'b000, 3'b000, 32'h0000_0100, 1, 1, 0, "R1 precedence");
        // virtualized gate
        send(2'd3, 2'd1, 1, 3'b111, 3'b011, 3'b000, 32'h0000_0200, 1, 1, 0, "R2 hyp bit");
        send(2'd0, 2'd0, 1, 3'b111, 3'b111, 3'b110, 32'h0000_0300, 1, 1, 0, "R2 user sup bit");
        // supervisor gate
        send(2'd1, 2'd0, 0, 3'b111, 3'b000, 3'b101, 32'h0000_0400, 1, 1, 0, "R3 user");
        send(2'd1, 2'd1, 0, 3'b111, 3'b000, 3'b000, 32'h0000_0440, 1, 1, 0, "R3 sup not gated");
        // bit selection
        send(2'd1, 2'd1, 0, 3'b101, 3'b111, 3'b111, 32'h0000_0500, 1, 1, 0, "R4 clean bit1");
        send(2'd2, 2'd1, 0, 3'b101, 3'b111, 3'b111, 32'h0000_0540, 1, 1, 0, "R4 flush bit1");
        send(2'd3, 2'd0, 0, 3'b100, 3'b000, 3'b100, 32'h0000_0580, 1, 1, 0, "R4 inval bit2");
        send(2'd0, 2'd0, 0, 3'b001, 3'b000, 3'b001, 32'h0000_05C0, 1, 1, 0, "R4 zero bit0");
        // zero operation
        send(2'd0, 2'd1, 0, 3'b111, 3'b000, 3'b000, 32'h0000_0600, 1, 1, 1, "R6 zero ok");
        send(2'd0, 2'd1, 0, 3'b111, 3'b000, 3'b000, 32'h0000_0640, 1, 0, 0, "R6 zero fault");
        send(2'd0, 2'd1, 1, 3'b111, 3'b111, 3'b000, 32'h0000_0680, 1, 0, 3, "R6 zero guest");
        // fallback
        send(2'd1, 2'd1, 0, 3'b111, 3'b000, 3'b000, 32'h0000_0700, 0, 1, 0, "R8 clean store ok");
        send(2'd2, 2'd1, 1, 3'b111, 3'b111, 3'b000, 32'h0000_0740, 0, 0, 1, "R8 flush guest");
        send(2'd3, 2'd0, 0, 3'b111, 3'b000, 3'b111, 32'h0000_0780, 0, 0, 0, "R8 inval page");
        // alignment
        send(2'd3, 2'd3, 0, 3'b000, 3'b000, 3'b000, 32'h1234_567F, 1, 0, 0, "R5 align top");
        send(2'd0, 2'd3, 0, 3'b000, 3'b000, 3'b000, 32'hFFFF_FFFF, 0, 1, 3, "R5 R10 align max");
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule